// File: doc/BRIEF.md
# Striped Cluster Record Assembler

The block collects cluster records that arrive striped over six parallel byte lanes. Every lane carries six bytes of each record, so one record is 36 bytes. Each lane keeps a small byte buffer of its own. A lane may run a few bytes ahead of the others without losing data. A record is released only when every lane holds at least six bytes. The released record leaves the block as nine consecutive 32-bit words.

Events have no fixed length. A separate end-of-event strobe closes the current event. The block wraps each event in one header word and one trailer word. The trailer reports how many clusters the event held and two error flags. One flag marks a partial record that was dropped. The other marks a lane that ran too far ahead. The output is a write-strobe word stream with no backpressure.

Top module: `clu_asm`

## Requirements
- R1: While reset is asserted, and after it until the first event activity, `out_wr` stays low. The first event number is 0.
- R2: The first word of every event is the header `{16'hC1A5, event_number[15:0]}`. The event number increments by one after each trailer.
- R3: A record is released only when all six lanes hold at least six bytes. It is emitted as nine words on consecutive cycles. The 36 bytes are ordered lane-major: lane 0 bytes 0..5, then lane 1, and so on. The first byte occupies bits 31:24 of the first word.
- R4: A byte that arrives on a lane beyond that lane's first six bytes is kept for the following record. Each lane holds up to 10 bytes.
- R5: After end-of-event, the block first emits every complete record. It then emits the trailer `{8'hE0, 6'b0, trunc, skew, cluster_count[15:0]}`, with trunc at bit 17 and skew at bit 16.
- R6: If any lane holds unreleased bytes when the event closes, those bytes are discarded and trunc is set. The next event starts with empty lanes.
- R7: skew is set for the event when, after any cycle, one lane holds more than 4 bytes more than the emptiest lane. skew is also set when a byte arrives on a lane that already holds 10 bytes; that byte is dropped.
- R8: An end-of-event with no clusters produces a header followed by a trailer with a count of 0.
- R9: Each output word appears one cycle after the cycle whose state triggers it. Record words follow each other without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_vld | input | 6 | Per-lane byte strobe |
| lane_byte | input | 48 | Lane l byte at bits 8l+7:8l |
| eoe | input | 1 | End-of-event strobe |
| out_wr | output | 1 | Output word valid |
| out_word | output | 32 | Output word |

## Verification
The header appears one cycle after the first cycle in which a record is complete or an end-of-event is pending. The first record word follows one cycle after that. The other eight record words follow on the next eight cycles. The trailer appears one cycle after the emitter is idle, no complete record is held and an end-of-event is pending. The bench model advances at every rising edge from the same inputs the design sees. It compares the write strobe and the word at the following falling edge, so every result is checked in the exact cycle it is due. Whole-event checks then read the captured words after a quiet period of 30 cycles.

// File: rtl/clu_asm.sv
module clu_asm #(
  parameter int LANES      = 6,
  parameter int BPL        = 6,
  parameter int SKEW_LIM   = 4,
  parameter int LANE_DEPTH = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANES-1:0]   lane_vld,
  input  logic [LANES*8-1:0] lane_byte,
  input  logic               eoe,
  output logic               out_wr,
  output logic [31:0]        out_word
);
  localparam int REC_W = LANES*BPL*8;
  localparam int WORDS = REC_W/32;
  localparam int CW    = $clog2(LANE_DEPTH+1);
  localparam int WLW   = $clog2(WORDS+1);
  localparam logic [CW-1:0]  BPL_C = CW'(BPL);
  localparam logic [CW-1:0]  DEP_C = CW'(LANE_DEPTH);
  localparam logic [CW-1:0]  SKW_C = CW'(SKEW_LIM);
  localparam logic [WLW-1:0] RELOAD = WLW'(WORDS-1);

  logic [7:0]     lbuf [LANES][LANE_DEPTH];
  logic [7:0]     nbuf [LANES][LANE_DEPTH];
  logic [CW-1:0]  cnt  [LANES];
  logic [CW-1:0]  ncnt [LANES];
  logic [REC_W-1:0] rec, srec;
  logic [WLW-1:0] wleft;
  logic [15:0]    evt_id, clu_cnt;
  logic hdr_sent, eoe_pend, skew_err;
  logic complete, trunc_now, skew_now, drop_now;
  logic idle, do_hdr, do_pop, do_close;

  always_comb begin
    complete  = 1'b1;
    trunc_now = 1'b0;
    rec       = '0;
    for (int l = 0; l < LANES; l++) begin
      if (cnt[l] < BPL_C) complete = 1'b0;
      if (cnt[l] != '0)   trunc_now = 1'b1;
      for (int b = 0; b < BPL; b++)
        rec[REC_W-1-8*(l*BPL+b) -: 8] = lbuf[l][b];
    end
  end

  assign idle     = (wleft == '0);
  assign do_hdr   = idle && !hdr_sent && (complete || eoe_pend);
  assign do_pop   = idle && hdr_sent && complete;
  assign do_close = idle && hdr_sent && eoe_pend && !complete;

  always_comb begin
    logic [CW-1:0] base, mx, mn;
    drop_now = 1'b0;
    mx = '0;
    mn = DEP_C;
    for (int l = 0; l < LANES; l++) begin
      nbuf[l] = lbuf[l];
      base = cnt[l];
      if (do_pop) begin
        base = cnt[l] - BPL_C;
        for (int k = 0; k < LANE_DEPTH-BPL; k++) nbuf[l][k] = lbuf[l][k+BPL];
        for (int k = LANE_DEPTH-BPL; k < LANE_DEPTH; k++) nbuf[l][k] = '0;
      end
      ncnt[l] = base;
      if (do_close) begin
        ncnt[l] = '0;
      end else if (lane_vld[l]) begin
        if (base < DEP_C) begin
          nbuf[l][base] = lane_byte[8*l +: 8];
          ncnt[l] = base + 1'b1;
        end else begin
          drop_now = 1'b1;
        end
      end
      if (ncnt[l] > mx) mx = ncnt[l];
      if (ncnt[l] < mn) mn = ncnt[l];
    end
    skew_now = (mx - mn) > SKW_C;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < LANES; l++) begin
        cnt[l] <= '0;
        for (int k = 0; k < LANE_DEPTH; k++) lbuf[l][k] <= '0;
      end
      srec     <= '0;
      wleft    <= '0;
      evt_id   <= '0;
      clu_cnt  <= '0;
      hdr_sent <= 1'b0;
      eoe_pend <= 1'b0;
      skew_err <= 1'b0;
      out_wr   <= 1'b0;
      out_word <= '0;
    end else begin
      lbuf     <= nbuf;
      cnt      <= ncnt;
      eoe_pend <= do_close ? 1'b0 : (eoe_pend | eoe);
      skew_err <= do_close ? 1'b0 : (skew_err | skew_now | drop_now);
      if (do_hdr)   hdr_sent <= 1'b1;
      if (do_close) hdr_sent <= 1'b0;
      if (do_pop)   clu_cnt  <= clu_cnt + 16'd1;
      if (do_close) clu_cnt  <= '0;
      if (do_close) evt_id   <= evt_id + 16'd1;
      out_wr <= do_hdr | do_pop | do_close | !idle;
      if (do_hdr)
        out_word <= {16'hC1A5, evt_id};
      else if (do_pop)
        out_word <= rec[REC_W-1 -: 32];
      else if (do_close)
        out_word <= {8'hE0, 6'd0, trunc_now, skew_err, clu_cnt};
      else if (!idle)
        out_word <= srec[REC_W-1 -: 32];
      if (do_pop) begin
        srec  <= rec << 32;
        wleft <= RELOAD;
      end else if (!idle) begin
        srec  <= srec << 32;
        wleft <= wleft - 1'b1;
      end
    end
  end
endmodule

// File: rtl/clu_asm_chk.sv
module clu_asm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        out_wr,
  input logic [31:0] out_word,
  input logic        hdr_sent,
  input logic        do_pop,
  input logic        do_close,
  input logic        busy,
  input logic        skew_err,
  input logic        trunc_now
);
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !out_wr);
  p_hdr_before_rec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |-> hdr_sent);
  p_rec_from_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |-> !busy);
  p_trailer_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    do_close |=> (out_wr && out_word[31:24] == 8'hE0));
  p_trunc_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (do_close && trunc_now) |=> out_word[17]);
  p_skew_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (skew_err && !do_close) |=> skew_err);
  p_event_reopen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    do_close |=> !hdr_sent);
  p_no_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> out_wr);
endmodule

bind clu_asm clu_asm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_wr(out_wr), .out_word(out_word),
  .hdr_sent(hdr_sent), .do_pop(do_pop), .do_close(do_close),
  .busy(wleft != '0), .skew_err(skew_err), .trunc_now(trunc_now)
);

// File: tb/tb_clu_asm.sv
module tb_clu_asm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  lane_vld = '0;
  logic [47:0] lane_byte = '0;
  logic        eoe = 1'b0;
  logic        out_wr;
  logic [31:0] out_word;

  always #5 clk = ~clk;

  clu_asm dut (.clk(clk), .rst_n(rst_n), .lane_vld(lane_vld), .lane_byte(lane_byte),
               .eoe(eoe), .out_wr(out_wr), .out_word(out_word));

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  int seq [6];
  logic [31:0] cap [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] byte_of(input int l, input int s);
    return 8'(l*37 + s*11 + 3);
  endfunction

  // behavioural reference model
  int          lq [6][$];
  logic [31:0] wq [$];
  bit          m_hdr, m_eoep, m_skew;
  int          m_cnt, m_evt;
  bit          exp_wr;
  logic [31:0] exp_word;
  string       exp_tag;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      foreach (lq[l]) lq[l].delete();
      wq.delete();
      m_hdr = 0; m_eoep = 0; m_skew = 0; m_cnt = 0; m_evt = 0;
      exp_wr = 0; exp_word = '0; exp_tag = "R1";
    end else begin
      bit idle, complete, close, trunc, drop;
      int mx, mn;
      idle = (wq.size() == 0);
      complete = 1;
      trunc = 0;
      for (int l = 0; l < 6; l++) begin
        if (lq[l].size() < 6) complete = 0;
        if (lq[l].size() > 0) trunc = 1;
      end
      close = 0;
      exp_wr = 0;
      if (idle && !m_hdr && (complete || m_eoep)) begin
        exp_wr = 1; exp_word = {16'hC1A5, 16'(m_evt)}; exp_tag = "R2"; m_hdr = 1;
      end else if (idle && m_hdr && complete) begin
        logic [7:0] bs [36];
        for (int l = 0; l < 6; l++)
          for (int b = 0; b < 6; b++) bs[l*6+b] = 8'(lq[l].pop_front());
        for (int w = 0; w < 9; w++) wq.push_back({bs[4*w], bs[4*w+1], bs[4*w+2], bs[4*w+3]});
        exp_wr = 1; exp_word = wq.pop_front(); exp_tag = "R3"; m_cnt++;
      end else if (idle && m_hdr && m_eoep) begin
        exp_wr = 1; exp_tag = "R5"; close = 1;
        exp_word = {8'hE0, 6'd0, trunc, m_skew, 16'(m_cnt)};
      end else if (!idle) begin
        exp_wr = 1; exp_word = wq.pop_front(); exp_tag = "R3";
      end
      drop = 0;
      if (close) begin
        foreach (lq[l]) lq[l].delete();
      end else begin
        for (int l = 0; l < 6; l++)
          if (lane_vld[l]) begin
            if (lq[l].size() < 10) lq[l].push_back(int'(lane_byte[8*l +: 8]));
            else drop = 1;
          end
      end
      mx = 0; mn = 10;
      for (int l = 0; l < 6; l++) begin
        if (lq[l].size() > mx) mx = lq[l].size();
        if (lq[l].size() < mn) mn = lq[l].size();
      end
      if (close) begin
        m_skew = 0; m_hdr = 0; m_cnt = 0; m_evt++; m_eoep = 0;
      end else begin
        if (mx - mn > 4 || drop) m_skew = 1;
        if (eoe) m_eoep = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(out_wr === exp_wr, "R9 write strobe", {31'd0, out_wr}, {31'd0, exp_wr});
      if (exp_wr) chk(out_word === exp_word, exp_tag, out_word, exp_word);
      if (out_wr) cap.push_back(out_word);
    end
  end

  task automatic step(input logic [5:0] m, input bit e);
    @(negedge clk);
    lane_vld = m;
    eoe = e;
    for (int l = 0; l < 6; l++)
      if (m[l]) begin
        lane_byte[8*l +: 8] = byte_of(l, seq[l]);
        seq[l]++;
      end
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) step(6'h00, 1'b0);
  endtask

  task automatic send_all(input int n);
    for (int c = 0; c < n; c++)
      for (int b = 0; b < 6; b++) begin
        step(6'h3F, 1'b0);
        step(6'h00, 1'b0);
      end
  endtask

  task automatic close_evt;
    step(6'h00, 1'b1);
    quiet(30);
  endtask

  task automatic check_evt(input int id, input int n, input bit tr, input bit sk, input string tag);
    logic [31:0] t;
    chk(cap.size() == 2 + 9*n, {tag, " word count"}, 32'(cap.size()), 32'(2 + 9*n));
    chk(cap[0] == {16'hC1A5, 16'(id)}, "R2 header", cap[0], {16'hC1A5, 16'(id)});
    t = cap[cap.size()-1];
    chk(t == {8'hE0, 6'd0, tr, sk, 16'(n)}, tag, t, {8'hE0, 6'd0, tr, sk, 16'(n)});
  endtask

  initial begin
    foreach (seq[l]) seq[l] = 0;
    repeat (4) @(negedge clk);
    chk(out_wr === 1'b0, "R1 reset strobe", {31'd0, out_wr}, 32'd0);
    rst_n = 1'b1;
    quiet(5);
    chk(out_wr === 1'b0 && cap.size() == 0, "R1 idle after reset", 32'(cap.size()), 32'd0);

    // event 0: two aligned clusters
    cap.delete();
    send_all(2);
    close_evt();
    check_evt(0, 2, 0, 0, "R5 trailer two clusters");
    chk(cap[1] == {byte_of(0,0), byte_of(0,1), byte_of(0,2), byte_of(0,3)},
        "R3 lane 0 byte 0 first", cap[1], {byte_of(0,0), byte_of(0,1), byte_of(0,2), byte_of(0,3)});
    chk(cap[9] == {byte_of(5,2), byte_of(5,3), byte_of(5,4), byte_of(5,5)},
        "R3 last record word", cap[9], {byte_of(5,2), byte_of(5,3), byte_of(5,4), byte_of(5,5)});

    // event 1: empty
    cap.delete();
    close_evt();
    check_evt(1, 0, 0, 0, "R8 empty event");

    // event 2: lane 0 runs ahead within tolerance
    begin
      int s0;
      s0 = seq[0];
      cap.delete();
      for (int i = 0; i < 4; i++) step(6'h3F, 1'b0);
      for (int i = 0; i < 4; i++) step(6'h01, 1'b0);
      for (int i = 0; i < 2; i++) step(6'h3E, 1'b0);
      for (int i = 0; i < 4; i++) step(6'h3F, 1'b0);
      for (int i = 0; i < 2; i++) step(6'h3E, 1'b0);
      quiet(4);
      close_evt();
      check_evt(2, 2, 0, 0, "R4 carried bytes event");
      chk(cap[10] == {byte_of(0,s0+6), byte_of(0,s0+7), byte_of(0,s0+8), byte_of(0,s0+9)},
          "R4 early bytes open next record", cap[10],
          {byte_of(0,s0+6), byte_of(0,s0+7), byte_of(0,s0+8), byte_of(0,s0+9)});
    end

    // event 3: partial record at end of event
    cap.delete();
    send_all(1);
    for (int i = 0; i < 3; i++) step(6'h3F, 1'b0);
    quiet(2);
    close_evt();
    check_evt(3, 1, 1, 0, "R6 truncation flag");

    // event 4: clean after truncation
    begin
      int s0;
      s0 = seq[0];
      cap.delete();
      send_all(1);
      close_evt();
      check_evt(4, 1, 0, 0, "R6 clean next event");
      chk(cap[1] == {byte_of(0,s0), byte_of(0,s0+1), byte_of(0,s0+2), byte_of(0,s0+3)},
          "R6 no stale bytes", cap[1], {byte_of(0,s0), byte_of(0,s0+1), byte_of(0,s0+2), byte_of(0,s0+3)});
    end

    // event 5: lane 0 too far ahead
    cap.delete();
    for (int i = 0; i < 6; i++) step(6'h01, 1'b0);
    for (int i = 0; i < 6; i++) step(6'h3E, 1'b0);
    quiet(2);
    close_evt();
    check_evt(5, 1, 0, 1, "R7 skew flag");

    // event 6: overrun of a full lane, then no record
    cap.delete();
    for (int i = 0; i < 11; i++) step(6'h02, 1'b0);
    quiet(2);
    close_evt();
    check_evt(6, 0, 1, 1, "R7 overrun drop");

    // event 7: flags cleared again
    cap.delete();
    send_all(1);
    close_evt();
    check_evt(7, 1, 0, 0, "R7 flag cleared per event");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc > 50000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule